// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. The host side issues single-beat read or write requests through a valid/ready handshake. The block converts each request into pin-level activity on the RAM. That activity covers an address bus, two chip enables of opposite polarity (one active-low, one active-high), an active-low output enable and an active-low write strobe. The data bus is split into an output, a driver enable and an input, so the pad ring can build the bidirectional pin.

Every timing minimum is given as a whole number of clock cycles, rounded up from the nanosecond figure at the chosen clock. The sequence comes from a cycle counter that starts when a request is accepted. Every memory-side pin comes straight from a flop, so the RAM sees no combinational glitches. Both chip enables stay active around the whole write strobe, which means the strobe alone defines the write window. Between requests the RAM is held deselected.

Top module: `asram_ctl`

## Requirements
- R1: During and right after reset the block holds the following state: ready high, active-low enable high, active-high enable low, output enable and write strobe high, data driver off, and read-valid low.
- R2: In every cycle where ready is high, the RAM is deselected (active-low enable 1, active-high enable 0), output enable and write strobe are high, and the data driver is off.
- R3: A request is taken on a clock edge where valid and ready are both high, and ready falls in the next cycle. Valid held high while ready is low does not disturb the running operation, and that request is taken on the first edge after ready returns.
- R4: Counting cycles from k=0 (the cycle after acceptance), a write first holds the RAM selected with the write strobe high and the driver off for T_TURN cycles. It then drives the write strobe low for exactly T_WP cycles with the driver on. Address and write data are stable for that whole window.
- R5: After the write strobe rises, the driver keeps the same data on the bus for T_DH cycles with both enables still active, and then turns off.
- R6: A write keeps ready low for max(T_TURN+T_WP+T_DH, T_RC) cycles. Any cycles beyond the strobe and hold phases keep the RAM selected with the driver off.
- R7: A read keeps ready low for max(T_RC, T_AA) cycles. Throughout those cycles both enables are active, output enable is low, the write strobe is high and the driver is off.
- R8: A read raises read-valid for exactly one cycle, at k=T_AA. The read data it carries is the RAM input sampled on the clock edge that ends cycle k=T_AA-1.
- R9: The data driver is never on while output enable is low. It turns on only after output enable has been high for at least T_TURN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Read data |
| mem_addr | output | 13 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
The bench builds the block with T_TURN=2, T_WP=2, T_DS_MIN=2, T_DH=1, T_RC=6 and T_AA=3. With these values a write has a two-cycle turnaround, a two-cycle strobe, one hold cycle and one padding cycle. That puts every phase of R4 to R6, including the cycle-time padding, within reach of the checks. Read-valid lands in the middle of the read, not at its end, so R8 is checked apart from the end of the cycle. Back-to-back requests that alternate between read and write exercise the turnaround rule of R9 and the held-request rule of R3.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } op_t;

   typedef struct packed {
      logic ce_n;
      logic ce;
      logic oe_n;
      logic we_n;
      logic drv;
   } pin_t;

   localparam pin_t PINS_STANDBY = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_ctl_seq.sv
module asram_ctl_seq
   import asram_ctl_pkg::*;
#(
   parameter int unsigned W_LEN = 6,
   parameter int unsigned R_LEN = 5,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   output logic             ready,
   output logic             accept,
   output op_t              op_q,
   output op_t              op_d,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d
);

   localparam logic [CNT_W-1:0] W_LAST = CNT_W'(W_LEN - 1);
   localparam logic [CNT_W-1:0] R_LAST = CNT_W'(R_LEN - 1);

   assign ready = (op_q == OP_IDLE);

   always_comb begin
      op_d   = op_q;
      cnt_d  = cnt_q;
      accept = 1'b0;
      unique case (op_q)
         OP_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               op_d   = req_write ? OP_WRITE : OP_READ;
               cnt_d  = '0;
            end
         end
         OP_WRITE: begin
            if (cnt_q == W_LAST) begin
               op_d  = OP_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         OP_READ: begin
            if (cnt_q == R_LAST) begin
               op_d  = OP_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            op_d  = OP_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_IDLE;
         cnt_q <= '0;
      end else begin
         op_q  <= op_d;
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/asram_ctl_pindec.sv
module asram_ctl_pindec
   import asram_ctl_pkg::*;
#(
   parameter int unsigned T_WP   = 4,
   parameter int unsigned T_DH   = 1,
   parameter int unsigned T_TURN = 4,
   parameter int unsigned CNT_W  = 4
) (
   input  op_t              op,
   input  logic [CNT_W-1:0] cnt,
   output pin_t             pins
);

   localparam int unsigned STROBE_LO = T_TURN;
   localparam int unsigned STROBE_HI = T_TURN + T_WP;
   localparam int unsigned DRIVE_HI  = STROBE_HI + T_DH;

   logic [31:0] k;
   logic        in_strobe;
   logic        in_drive;

   assign k         = {{(32-CNT_W){1'b0}}, cnt};
   assign in_strobe = (k >= STROBE_LO) && (k < STROBE_HI);
   assign in_drive  = (k >= STROBE_LO) && (k < DRIVE_HI);

   always_comb begin
      pins = PINS_STANDBY;
      unique case (op)
         OP_WRITE: begin
            pins.ce_n = 1'b0;
            pins.ce   = 1'b1;
            pins.oe_n = 1'b1;
            pins.we_n = ~in_strobe;
            pins.drv  = in_drive;
         end
         OP_READ: begin
            pins.ce_n = 1'b0;
            pins.ce   = 1'b1;
            pins.oe_n = 1'b0;
            pins.we_n = 1'b1;
            pins.drv  = 1'b0;
         end
         default: pins = PINS_STANDBY;
      endcase
   end

endmodule

// File: rtl/asram_ctl_dpath.sv
module asram_ctl_dpath
   import asram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned T_AA   = 5,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  pin_t              pins_d,
   input  op_t               op_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [DATA_W-1:0] mem_dq_in,
   output pin_t              pins_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(T_AA - 1);

   logic sample;
   assign sample = (op_q == OP_READ) && (cnt_q == SAMPLE_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= PINS_STANDBY;
      else        pins_q <= pins_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= sample;
         if (sample) rsp_data <= mem_dq_in;
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned T_WP     = 4,
   parameter int unsigned T_DS_MIN = 2,
   parameter int unsigned T_DH     = 1,
   parameter int unsigned T_RC     = 5,
   parameter int unsigned T_AA     = 5,
   parameter int unsigned T_TURN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned W_BUSY = T_TURN + T_WP + T_DH;
   localparam int unsigned W_LEN  = imax(W_BUSY, T_RC);
   localparam int unsigned R_LEN  = imax(T_RC, T_AA);
   localparam int unsigned CNT_W  = $clog2(imax(W_LEN, R_LEN) + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctl: address and data widths must be at least 1");
      end
      if (T_WP < 1 || T_DH < 1 || T_AA < 1 || T_TURN < 1 || T_RC < 1) begin : g_bad_timing
         $error("asram_ctl: every cycle-count parameter must be at least 1");
      end
      if (T_DS_MIN > T_WP) begin : g_bad_setup
         $error("asram_ctl: data is driven from the strobe start, so T_DS_MIN may not exceed T_WP");
      end
   endgenerate

   logic             accept;
   op_t              op_q;
   op_t              op_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   pin_t             pins_d;
   pin_t             pins_q;

   asram_ctl_seq #(
      .W_LEN (W_LEN),
      .R_LEN (R_LEN),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .ready     (req_ready),
      .accept    (accept),
      .op_q      (op_q),
      .op_d      (op_d),
      .cnt_q     (cnt_q),
      .cnt_d     (cnt_d)
   );

   asram_ctl_pindec #(
      .T_WP   (T_WP),
      .T_DH   (T_DH),
      .T_TURN (T_TURN),
      .CNT_W  (CNT_W)
   ) u_dec (
      .op   (op_d),
      .cnt  (cnt_d),
      .pins (pins_d)
   );

   asram_ctl_dpath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .T_AA   (T_AA),
      .CNT_W  (CNT_W)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .pins_d     (pins_d),
      .op_q       (op_q),
      .cnt_q      (cnt_q),
      .mem_dq_in  (mem_dq_in),
      .pins_q     (pins_q),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   assign mem_ce_n  = pins_q.ce_n;
   assign mem_ce    = pins_q.ce;
   assign mem_oe_n  = pins_q.oe_n;
   assign mem_we_n  = pins_q.we_n;
   assign mem_dq_oe = pins_q.drv;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned T_WP   = 4,
   parameter int unsigned T_TURN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_ce,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int unsigned LIM = ((T_WP > T_TURN) ? T_WP : T_TURN) + 1;
   localparam int unsigned CW  = $clog2(LIM + 1);
   localparam logic [CW-1:0] SAT = CW'(LIM);

   logic [CW-1:0] strobe_len;
   logic [CW-1:0] oe_high_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_len  <= '0;
         oe_high_len <= '0;
      end else begin
         if (!mem_we_n) strobe_len <= (strobe_len == SAT) ? SAT : strobe_len + 1'b1;
         else           strobe_len <= '0;
         if (mem_oe_n)  oe_high_len <= (oe_high_len == SAT) ? SAT : oe_high_len + 1'b1;
         else           oe_high_len <= '0;
      end
   end

   p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_busy_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_strobe_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe));

   p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (strobe_len >= CW'(T_WP)));

   p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && mem_ce && $stable(mem_dq_out) && $stable(mem_addr)));

   p_read_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_ce_n && mem_ce));

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && (oe_high_len >= CW'(T_TURN))));

endmodule

bind asram_ctl asram_ctl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .T_WP   (T_WP),
   .T_TURN (T_TURN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_ce     (mem_ce),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctl_test.sv
module asram_ctl_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int P_WP = 2;
   localparam int P_DS = 2;
   localparam int P_DH = 1;
   localparam int P_RC = 6;
   localparam int P_AA = 3;
   localparam int P_TURN = 2;
   localparam int W_BUSY = P_TURN + P_WP + P_DH;
   localparam int W_LEN = (W_BUSY > P_RC) ? W_BUSY : P_RC;
   localparam int R_LEN = (P_RC > P_AA) ? P_RC : P_AA;

   logic          clk;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic          req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n;
   logic          mem_ce;
   logic          mem_oe_n;
   logic          mem_we_n;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic [DW-1:0] mem_dq_in;

   int n_checks = 0;
   int n_errors = 0;

   asram_ctl #(
      .ADDR_W (AW), .DATA_W (DW), .T_WP (P_WP), .T_DS_MIN (P_DS),
      .T_DH (P_DH), .T_RC (P_RC), .T_AA (P_AA), .T_TURN (P_TURN)
   ) uut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
      .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_data (rsp_data), .mem_addr (mem_addr),
      .mem_ce_n (mem_ce_n), .mem_ce (mem_ce), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
      .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // Device model: sparse storage, unwritten bytes follow a fixed pattern
   logic [DW-1:0] dev_mem [int];
   logic [DW-1:0] exp_mem [int];

   function automatic logic [DW-1:0] init_byte(input int a);
      return DW'(a * 7 + 3) ^ DW'(a >> 5);
   endfunction

   always @(negedge clk) begin
      if (mem_ce_n === 1'b0 && mem_ce === 1'b1 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
         mem_dq_in = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : init_byte(int'(mem_addr));
      else
         mem_dq_in = 8'hzz;
   end

   always @(posedge mem_we_n) begin
      if (mem_ce_n === 1'b0 && mem_ce === 1'b1 && mem_dq_oe === 1'b1)
         dev_mem[int'(mem_addr)] = mem_dq_out;
   end

   function automatic logic [6:0] pins_now();
      return {req_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid};
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
   endtask

   // Follows one operation accepted at the coming edge; optionally presents the next request
   task automatic follow(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit keep, input bit nwr, input logic [AW-1:0] na, input logic [DW-1:0] nd);
      int len;
      logic [DW-1:0] expd;
      logic [6:0] e;
      len = wr ? W_LEN : R_LEN;
      expd = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(int'(a));
      @(posedge clk);
      @(negedge clk);
      if (keep) issue(nwr, na, nd);
      else      req_valid = 1'b0;
      check(req_ready == 1'b0, "R3", "ready low after acceptance", int'(req_ready), 0);
      for (int k = 0; k < len; k++) begin
         string tag;
         bit strobe;
         bit drv;
         if (wr) begin
            strobe = (k >= P_TURN) && (k < P_TURN + P_WP);
            drv    = (k >= P_TURN) && (k < W_BUSY);
            e = {1'b0, 1'b0, 1'b1, 1'b1, ~strobe, drv, 1'b0};
            tag = (k < P_TURN) ? "R9" : strobe ? "R4" : drv ? "R5" : "R6";
            if (drv) check(mem_dq_out == d, tag, "write data on bus", int'(mem_dq_out), int'(d));
         end else begin
            e = {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, (k == P_AA)};
            tag = (k == P_AA) ? "R8" : "R7";
            if (k == P_AA) check(rsp_data == expd, "R8", "read data", int'(rsp_data), int'(expd));
         end
         check(pins_now() == e, tag, $sformatf("pins at k=%0d", k), int'(pins_now()), int'(e));
         check(mem_addr == a, tag, "address", int'(mem_addr), int'(a));
         @(negedge clk);
      end
      e = {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, (!wr && P_AA == len)};
      check(pins_now() == e, "R2", "standby after operation", int'(pins_now()), int'(e));
      if (wr) exp_mem[int'(a)] = d;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr = '0;
      req_wdata = '0;
      repeat (3) @(negedge clk);
      check(pins_now() == 7'b1101100, "R1", "pins in reset", int'(pins_now()), 'h6c);
      rst_n = 1'b1;
      @(negedge clk);
      check(pins_now() == 7'b1101100, "R1", "pins after reset", int'(pins_now()), 'h6c);
      repeat (3) begin
         @(negedge clk);
         check(pins_now() == 7'b1101100, "R2", "standby without request", int'(pins_now()), 'h6c);
      end

      // Plain write then read back
      issue(1'b1, 13'h0000, 8'hA5);
      follow(1'b1, 13'h0000, 8'hA5, 1'b0, 1'b0, '0, '0);
      issue(1'b0, 13'h0000, 8'h00);
      follow(1'b0, 13'h0000, 8'h00, 1'b0, 1'b0, '0, '0);

      // Unwritten top address returns the stored pattern
      issue(1'b0, 13'h1FFF, 8'h00);
      follow(1'b0, 13'h1FFF, 8'h00, 1'b0, 1'b0, '0, '0);

      // R3: request held high during a write, taken after ready returns
      issue(1'b1, 13'h1FFF, 8'h3C);
      follow(1'b1, 13'h1FFF, 8'h3C, 1'b1, 1'b0, 13'h1FFF, 8'h00);
      follow(1'b0, 13'h1FFF, 8'h00, 1'b0, 1'b0, '0, '0);

      // R9: read followed at once by write, then read, all back to back
      issue(1'b0, 13'h0ABC, 8'h00);
      follow(1'b0, 13'h0ABC, 8'h00, 1'b1, 1'b1, 13'h0ABC, 8'h96);
      follow(1'b1, 13'h0ABC, 8'h96, 1'b1, 1'b0, 13'h0ABC, 8'h00);
      follow(1'b0, 13'h0ABC, 8'h00, 1'b0, 1'b0, '0, '0);

      // Varied addresses and data
      for (int i = 1; i < 7; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         a = AW'(i * 1237);
         d = DW'(i * 37 + 1);
         issue(1'b1, a, d);
         follow(1'b1, a, d, 1'b0, 1'b0, '0, '0);
      end
      for (int i = 6; i > 0; i--) begin
         logic [AW-1:0] a;
         a = AW'(i * 1237);
         issue(1'b0, a, 8'h00);
         follow(1'b0, a, 8'h00, 1'b0, 1'b0, '0, '0);
      end

      repeat (2) begin
         @(negedge clk);
         check(pins_now() == 7'b1101100, "R2", "standby at end", int'(pins_now()), 'h6c);
      end

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule